// File: doc/BRIEF.md
# Spare Cache Slice Chain Table

This block sits in each cache controller of an eight-position multicore chip in which some cores are disabled at test but keep working cache slices. It holds three small tables, one entry per core position. The first is an allocation mask per working core, showing which spare slices that core searches for data. The second is a link entry per position that names the next slice in a chain or marks that the chain goes on to main memory. The third is a sharer mask per spare slice, showing which working cores may hold data in it for coherence purposes.

System software fills the tables through a single configuration write port. It may do so at boot, before a program starts, or while a program runs. Three lookup paths read the tables combinationally:

- Given a requesting core, one path returns that core's allocation mask and its first link.
- Given any position, one path returns the link entry used to move a block on eviction or promotion.
- Given a spare slice, one path returns its sharer mask.

A walker follows a chain from a start position and emits one hop per cycle until the chain reaches memory. It also stops after eight hops, which catches a chain that loops back on itself.

Top module: `ecc_chain_table`

## Requirements
- R1: After reset, every allocation mask and sharer mask reads zero and every link entry reads invalid, so every core goes straight to memory.
- R2: A configuration write with cfg_sel = 0 stores cfg_data as the allocation mask of position cfg_pos. It is read back on alloc_vec when req_core equals that position. Bit n set means the slice at position n is assigned to that core.
- R3: first_valid and first_idx give the link entry of position req_core.
- R4: A configuration write with cfg_sel = 1 stores a link entry for cfg_pos:
  - cfg_data[3] is the valid bit and cfg_data[2:0] is the next position.
  - cfg_data[7:4] are ignored.
  - For any hop_pos, next_valid and next_idx return that position's entry.
  - A clear valid bit means the next level is main memory.
- R5: A configuration write with cfg_sel = 2 stores cfg_data as the sharer mask of position cfg_pos. It is read on shr_vec for shr_pos.
- R6: A lookup made in the same cycle as a write to the same entry returns the old value. The new value is visible from the next cycle on.
- R7: A walk accepted on walk_start from walk_pos proceeds as follows, with walk_busy high for the whole walk:
  - In each following cycle whose current entry is valid, it emits hop_valid with hop_idx equal to that entry's next position.
  - At the first invalid entry, it emits at_memory for one cycle and ends.
  - hop_valid and at_memory are never high together.
- R8: A walk that has emitted 8 hops and still finds a valid entry raises loop_err for one cycle and ends, without at_memory.
- R9: walk_start is ignored while a walk is in progress, and the running walk continues unchanged.
- R10: A write to one table leaves the other two tables unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Table select: 0 allocation, 1 link, 2 sharer |
| cfg_pos | input | 3 | Position written |
| cfg_data | input | 8 | Write data |
| req_core | input | 3 | Requesting core for the allocation lookup |
| alloc_vec | output | 8 | Allocation mask of req_core |
| first_valid | output | 1 | Link valid bit of req_core |
| first_idx | output | 3 | First hop of req_core |
| hop_pos | input | 3 | Position for the eviction/promotion lookup |
| next_valid | output | 1 | Link valid bit of hop_pos |
| next_idx | output | 3 | Next position after hop_pos |
| shr_pos | input | 3 | Spare slice for the sharer lookup |
| shr_vec | output | 8 | Sharer mask of shr_pos |
| walk_start | input | 1 | Start a chain walk |
| walk_pos | input | 3 | Start position of the walk |
| walk_busy | output | 1 | Walk in progress |
| hop_valid | output | 1 | A hop is emitted this cycle |
| hop_idx | output | 3 | Position reached by this hop |
| at_memory | output | 1 | Walk reached main memory |
| loop_err | output | 1 | Walk stopped on the hop limit |

## Verification
The walker is run on four kinds of chain, and each one tests a different failure:

- A four-link chain ending at memory tests hop order and termination.
- A start on a position whose entry is already invalid tests the immediate memory case with no hops.
- A two-position cycle tests the hop limit and the error flag.
- A second start request during a walk checks that a running walk cannot be disturbed.

The lookup paths are checked in three ways:

- Writes to each table are followed by reads of the other two, which catches a decode that mixes up the tables.
- Link data carrying junk in its upper bits catches decoding of the wrong field.
- A write and a read of the same entry in one cycle separates old-value from new-value behaviour.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
  typedef enum logic [1:0] {
    SEL_ALLOC = 2'd0,
    SEL_LINK  = 2'd1,
    SEL_SHARE = 2'd2
  } cfg_sel_e;
endpackage

// File: rtl/ecc_reg_bank.sv
module ecc_reg_bank #(
  parameter int N = 8,
  parameter int W = 8,
  localparam int AW = $clog2(N)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [AW-1:0]       waddr,
  input  logic [W-1:0]        wdata,
  output logic [N-1:0][W-1:0] rows
);
  for (genvar i = 0; i < N; i++) begin : g_row
    always_ff @(posedge clk) begin
      if (!rst_n)
        rows[i] <= '0;
      else if (we && waddr == AW'(i))
        rows[i] <= wdata;
    end
  end
endmodule

// File: rtl/ecc_walker.sv
module ecc_walker #(
  parameter int NPOS = 8,
  localparam int IDXW = $clog2(NPOS),
  localparam int LINKW = IDXW + 1,
  localparam int CNTW = $clog2(NPOS + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [IDXW-1:0]            start_pos,
  input  logic [NPOS-1:0][LINKW-1:0] links,
  output logic                       busy,
  output logic                       accept,
  output logic                       hop_valid,
  output logic [IDXW-1:0]            hop_idx,
  output logic                       at_memory,
  output logic                       loop_err
);
  logic [IDXW-1:0] cur;
  logic [CNTW-1:0] cnt;
  logic            cur_live;
  logic            limit_hit;

  assign cur_live  = links[cur][IDXW];
  assign hop_idx   = links[cur][IDXW-1:0];
  assign limit_hit = (cnt == CNTW'(NPOS));
  assign accept    = start && !busy;
  assign hop_valid = busy && cur_live && !limit_hit;
  assign loop_err  = busy && cur_live && limit_hit;
  assign at_memory = busy && !cur_live;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cur  <= '0;
      cnt  <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      cur  <= start_pos;
      cnt  <= '0;
    end else if (busy) begin
      if (hop_valid) begin
        cur <= hop_idx;
        cnt <= cnt + 1'b1;
      end else begin
        busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ecc_chain_table.sv
module ecc_chain_table #(
  parameter int NPOS = 8,
  localparam int IDXW = $clog2(NPOS),
  localparam int LINKW = IDXW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_sel,
  input  logic [IDXW-1:0] cfg_pos,
  input  logic [NPOS-1:0] cfg_data,
  input  logic [IDXW-1:0] req_core,
  output logic [NPOS-1:0] alloc_vec,
  output logic            first_valid,
  output logic [IDXW-1:0] first_idx,
  input  logic [IDXW-1:0] hop_pos,
  output logic            next_valid,
  output logic [IDXW-1:0] next_idx,
  input  logic [IDXW-1:0] shr_pos,
  output logic [NPOS-1:0] shr_vec,
  input  logic            walk_start,
  input  logic [IDXW-1:0] walk_pos,
  output logic            walk_busy,
  output logic            hop_valid,
  output logic [IDXW-1:0] hop_idx,
  output logic            at_memory,
  output logic            loop_err
);
  import ecc_pkg::*;

  function automatic logic link_live(input logic [LINKW-1:0] e);
    return e[IDXW];
  endfunction

  function automatic logic [IDXW-1:0] link_next(input logic [LINKW-1:0] e);
    return e[IDXW-1:0];
  endfunction

  cfg_sel_e                  sel;
  logic                      we_alloc, we_link, we_share;
  logic                      walk_accept;
  logic [NPOS-1:0][NPOS-1:0] alloc_rows;
  logic [NPOS-1:0][NPOS-1:0] share_rows;
  logic [NPOS-1:0][LINKW-1:0] link_rows;

  assign sel      = cfg_sel_e'(cfg_sel);
  assign we_alloc = cfg_we && (sel == SEL_ALLOC);
  assign we_link  = cfg_we && (sel == SEL_LINK);
  assign we_share = cfg_we && (sel == SEL_SHARE);

  ecc_reg_bank #(.N(NPOS), .W(NPOS)) u_alloc (
    .clk(clk), .rst_n(rst_n), .we(we_alloc), .waddr(cfg_pos),
    .wdata(cfg_data), .rows(alloc_rows));

  ecc_reg_bank #(.N(NPOS), .W(LINKW)) u_link (
    .clk(clk), .rst_n(rst_n), .we(we_link), .waddr(cfg_pos),
    .wdata(cfg_data[LINKW-1:0]), .rows(link_rows));

  ecc_reg_bank #(.N(NPOS), .W(NPOS)) u_share (
    .clk(clk), .rst_n(rst_n), .we(we_share), .waddr(cfg_pos),
    .wdata(cfg_data), .rows(share_rows));

  assign alloc_vec   = alloc_rows[req_core];
  assign first_valid = link_live(link_rows[req_core]);
  assign first_idx   = link_next(link_rows[req_core]);
  assign next_valid  = link_live(link_rows[hop_pos]);
  assign next_idx    = link_next(link_rows[hop_pos]);
  assign shr_vec     = share_rows[shr_pos];

  ecc_walker #(.NPOS(NPOS)) u_walk (
    .clk(clk), .rst_n(rst_n), .start(walk_start), .start_pos(walk_pos),
    .links(link_rows), .busy(walk_busy), .accept(walk_accept),
    .hop_valid(hop_valid), .hop_idx(hop_idx), .at_memory(at_memory),
    .loop_err(loop_err));
endmodule

// File: rtl/ecc_chain_table_chk.sv
module ecc_chain_table_chk #(
  parameter int NPOS = 8,
  localparam int IDXW = $clog2(NPOS),
  localparam int CW = $clog2(NPOS + 1) + 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_we,
  input logic [1:0]      cfg_sel,
  input logic [IDXW-1:0] cfg_pos,
  input logic [NPOS-1:0] cfg_data,
  input logic [IDXW-1:0] req_core,
  input logic [NPOS-1:0] alloc_vec,
  input logic            first_valid,
  input logic            walk_accept,
  input logic            walk_busy,
  input logic            hop_valid,
  input logic            at_memory,
  input logic            loop_err
);
  logic [CW-1:0] hops_seen;

  always_ff @(posedge clk) begin
    if (!rst_n)            hops_seen <= '0;
    else if (walk_accept)  hops_seen <= '0;
    else if (hop_valid)    hops_seen <= hops_seen + 1'b1;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (alloc_vec == '0 && !first_valid));

  // R6
  write_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == 2'd0) |=>
      (req_core != $past(cfg_pos) || alloc_vec == $past(cfg_data)));

  // R7
  hop_mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hop_valid && at_memory));

  // R7
  mem_ends_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    at_memory |=> !walk_busy);

  // R8
  loop_ends_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loop_err |=> !walk_busy);

  // R8
  hop_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hop_valid |-> (hops_seen < CW'(NPOS)));

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_busy |-> !walk_accept);
endmodule

bind ecc_chain_table ecc_chain_table_chk #(.NPOS(NPOS)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
  .cfg_pos(cfg_pos), .cfg_data(cfg_data), .req_core(req_core),
  .alloc_vec(alloc_vec), .first_valid(first_valid),
  .walk_accept(walk_accept), .walk_busy(walk_busy), .hop_valid(hop_valid),
  .at_memory(at_memory), .loop_err(loop_err));

// File: tb/ecc_chain_table_test.sv
module ecc_chain_table_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [2:0] cfg_pos = '0;
  logic [7:0] cfg_data = '0;
  logic [2:0] req_core = '0, hop_pos = '0, shr_pos = '0, walk_pos = '0;
  logic walk_start = 1'b0;
  logic [7:0] alloc_vec, shr_vec;
  logic first_valid, next_valid, walk_busy, hop_valid, at_memory, loop_err;
  logic [2:0] first_idx, next_idx, hop_idx;

  int tests = 0;
  int fails = 0;

  typedef struct { int kind; int idx; } ev_t; // kind 0 hop, 1 memory, 2 loop
  ev_t sb[$];

  always #4 clk = ~clk;

  ecc_chain_table uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_pos(cfg_pos), .cfg_data(cfg_data), .req_core(req_core),
    .alloc_vec(alloc_vec), .first_valid(first_valid), .first_idx(first_idx),
    .hop_pos(hop_pos), .next_valid(next_valid), .next_idx(next_idx),
    .shr_pos(shr_pos), .shr_vec(shr_vec), .walk_start(walk_start),
    .walk_pos(walk_pos), .walk_busy(walk_busy), .hop_valid(hop_valid),
    .hop_idx(hop_idx), .at_memory(at_memory), .loop_err(loop_err));

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [1:0] s, input logic [2:0] p, input logic [7:0] d);
    cfg_we = 1'b1; cfg_sel = s; cfg_pos = p; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic push(input int kind, input int idx);
    ev_t e;
    e.kind = kind; e.idx = idx;
    sb.push_back(e);
  endtask

  task automatic walk(input logic [2:0] p);
    walk_start = 1'b1; walk_pos = p;
    @(negedge clk);
    walk_start = 1'b0;
  endtask

  // monitor: pops expected walker events as the design produces them
  always @(negedge clk) begin
    if (rst_n && (hop_valid || at_memory || loop_err)) begin
      int k;
      k = loop_err ? 2 : (at_memory ? 1 : 0);
      if (sb.size() == 0) begin
        chk("R7/R8 unexpected walk event", k, -1);
      end else begin
        ev_t e;
        e = sb.pop_front();
        chk("R7/R8 walk event kind", k, e.kind);
        if (e.kind == 0) chk("R7 hop index", int'(hop_idx), e.idx);
      end
    end
  end

  initial begin
    #(8 * 5000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: everything clear after reset
    for (int p = 0; p < 8; p++) begin
      req_core = 3'(p); hop_pos = 3'(p); shr_pos = 3'(p);
      #1;
      chk("R1 alloc", int'(alloc_vec), 0);
      chk("R1 first_valid", int'(first_valid), 0);
      chk("R1 next_valid", int'(next_valid), 0);
      chk("R1 sharer", int'(shr_vec), 0);
    end
    @(negedge clk);
    // R2 allocation write
    cfg_wr(2'd0, 3'd6, 8'h0D);
    req_core = 3'd6; hop_pos = 3'd6; shr_pos = 3'd6; #1;
    chk("R2 alloc core6", int'(alloc_vec), 'h0D);
    chk("R10 link untouched", int'(next_valid), 0);
    chk("R10 sharer untouched", int'(shr_vec), 0);
    // R5 sharer write
    @(negedge clk);
    cfg_wr(2'd2, 3'd3, 8'h45);
    shr_pos = 3'd3; req_core = 3'd3; #1;
    chk("R5 sharer slice3", int'(shr_vec), 'h45);
    chk("R10 alloc untouched", int'(alloc_vec), 0);
    // R4 chain 6->3->2->0->memory, junk in upper bits
    @(negedge clk);
    cfg_wr(2'd1, 3'd6, 8'h0B);
    cfg_wr(2'd1, 3'd3, 8'hAA);
    cfg_wr(2'd1, 3'd2, 8'hF8);
    req_core = 3'd6; hop_pos = 3'd2; #1;
    chk("R3 first_valid", int'(first_valid), 1);
    chk("R3 first_idx", int'(first_idx), 3);
    chk("R4 next_valid pos2", int'(next_valid), 1);
    chk("R4 next_idx pos2", int'(next_idx), 0);
    hop_pos = 3'd0; #1;
    chk("R4 pos0 to memory", int'(next_valid), 0);
    req_core = 3'd3; shr_pos = 3'd3; #1;
    chk("R10 alloc after link writes", int'(alloc_vec), 0);
    chk("R10 sharer after link writes", int'(shr_vec), 'h45);
    // R6 same-cycle write and lookup
    @(negedge clk);
    req_core = 3'd2;
    cfg_we = 1'b1; cfg_sel = 2'd0; cfg_pos = 3'd2; cfg_data = 8'hAA;
    #1;
    chk("R6 old value", int'(alloc_vec), 0);
    @(negedge clk);
    cfg_we = 1'b0;
    chk("R6 new value", int'(alloc_vec), 'hAA);
    // R7 + R9 chain walk with a second start ignored
    push(0, 3); push(0, 2); push(0, 0); push(1, 0);
    walk(3'd6);
    chk("R7 busy", int'(walk_busy), 1);
    walk(3'd1);
    repeat (8) @(negedge clk);
    chk("R7/R9 all chain events seen", sb.size(), 0);
    chk("R7 idle after walk", int'(walk_busy), 0);
    // R7 start on invalid entry goes straight to memory
    push(1, 0);
    walk(3'd0);
    repeat (3) @(negedge clk);
    chk("R7 direct memory seen", sb.size(), 0);
    // R8 loop 4<->5
    cfg_wr(2'd1, 3'd4, 8'h0D);
    cfg_wr(2'd1, 3'd5, 8'h0C);
    for (int i = 0; i < 8; i++) push(0, (i % 2 == 0) ? 5 : 4);
    push(2, 0);
    walk(3'd4);
    repeat (14) @(negedge clk);
    chk("R8 loop events seen", sb.size(), 0);
    chk("R8 idle after loop", int'(walk_busy), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule